// File: doc/BRIEF.md
# Elementary Check-Node Pair Merger for GF(256) Min-Sum Decoding

This block combines two truncated message vectors of a nonbinary min-sum decoder into one. Each input vector holds NM entries (field symbol plus reliability cost). The entries are sorted by increasing cost, and the best entry carries cost 0. The block searches the NM×NM pairs in increasing order of summed cost. The symbol of a pair is the bitwise XOR of its two symbols, which is addition in GF(2^SYM_W). The block streams out the NM cheapest distinct combined symbols, one per cycle, each with the cost of its cheapest pair.

The search works from a small insertion sorter. The sorter holds only the two row and column indices of a candidate and its summed cost. Each sorter slot serves two rows of the first input: row k and row k+DEPTH. After a slot's pair is popped, the slot is refilled with the cheaper of two candidates: the next column of the popped row, or the current head of its partner row. A combined symbol is rebuilt from the indices only when its entry leaves the sorter. A symbol that was already emitted is dropped.

Top module: `ecn_pair_merge`

## Requirements
- R1: A `start_i` pulse while idle captures both input vectors. Entry k of a vector sits at bits [k*W +: W] of its bus, and costs are nondecreasing with entry 0 at cost 0. A `start_i` while `busy_o` is high is ignored: the run in flight completes from the captured data, and no second run follows.
- R2: Every output symbol equals a_sym[i] XOR b_sym[j] for some pair (i,j), and its cost equals a_llr[i] + b_llr[j] for that same pair.
- R3: Exactly NM outputs are produced per run. The k-th output cost equals the k-th smallest value of the best-pair cost per symbol, taken over all NM×NM pairs.
- R4: No symbol appears twice among the outputs of one run.
- R5: Output costs are nondecreasing. The first output has cost a_llr[0]+b_llr[0] (zero) and symbol a_sym[0] XOR b_sym[0].
- R6: The first output appears DEPTH+1 clock edges after the edge that accepts `start_i`. When no duplicate symbol is popped, the NM outputs occupy NM consecutive cycles.
- R7: A popped pair whose symbol was already emitted produces no output cycle. The search continues until NM distinct symbols have been emitted.
- R8: `out_done_o` is high in the same cycle as the NM-th output, and `busy_o` is already low in that cycle.
- R9: The search reaches rows of the first input beyond the DEPTH preloaded ones, so all NM rows of column 0 can be emitted, and the sorter never holds more than DEPTH entries.
- R10: After reset, `busy_o`, `out_valid_o` and `out_done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; captures both vectors when idle |
| a_sym_i | input | NM*SYM_W | First vector symbols, entry k at [k*SYM_W +: SYM_W] |
| a_llr_i | input | NM*LLR_W | First vector costs, sorted nondecreasing |
| b_sym_i | input | NM*SYM_W | Second vector symbols |
| b_llr_i | input | NM*LLR_W | Second vector costs, sorted nondecreasing |
| busy_o | output | 1 | High from acceptance until the run ends |
| out_valid_o | output | 1 | An output entry is present |
| out_sym_o | output | SYM_W | Combined symbol |
| out_llr_o | output | LLR_W+1 | Combined cost |
| out_done_o | output | 1 | Run finished |

## Verification
The in-RTL assertions check four things on every cycle:
- the sorter stays ordered and never overflows;
- emitted costs never decrease within a run, and the first one matches the captured head entries;
- the captured vectors hold still while a start arrives during a run;
- the done pulse never coincides with a busy block.

Only the bench scenarios can show that the emitted set is the true best NM symbols. They compare against a full pair search, and they also cover the cycle timing, the gaps left by dropped duplicates, and the deep column and row paths.

// File: rtl/ecn_pkg.sv
`timescale 1ns/1ps
package ecn_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_RUN  = 2'd2
   } ecn_state_e;

   // row sharing a sorter slot with the given row
   function automatic int partner_row(input int row, input int half);
      return (row < half) ? row + half : row - half;
   endfunction
endpackage

// File: rtl/ecn_insert_sorter.sv
`timescale 1ns/1ps
module ecn_insert_sorter #(
   parameter int DEPTH = 6,
   parameter int IDX_W = 4,
   parameter int SUM_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             pop,
   input  logic             ins_valid,
   input  logic [IDX_W-1:0] ins_ia,
   input  logic [IDX_W-1:0] ins_ib,
   input  logic [SUM_W-1:0] ins_llr,
   output logic             head_valid,
   output logic [IDX_W-1:0] head_ia,
   output logic [IDX_W-1:0] head_ib,
   output logic [SUM_W-1:0] head_llr
);
   logic [DEPTH-1:0]            v_q, b_v, le, v_d;
   logic [DEPTH-1:0][IDX_W-1:0] ia_q, ib_q, b_ia, b_ib, ia_d, ib_d;
   logic [DEPTH-1:0][SUM_W-1:0] llr_q, b_l, llr_d;

   initial begin
      assert (DEPTH >= 1 && IDX_W >= 1 && SUM_W >= 1)
         else $error("ecn_insert_sorter: bad parameters");
   end

   always_comb begin
      int up;
      int dn;
      // base array: after a pop everything moves one place toward the head
      for (int m = 0; m < DEPTH; m++) begin
         up = (m < DEPTH - 1) ? m + 1 : DEPTH - 1;
         if (pop) begin
            b_v[m]  = v_q[up] & (m < DEPTH - 1);
            b_ia[m] = ia_q[up];
            b_ib[m] = ib_q[up];
            b_l[m]  = llr_q[up];
         end else begin
            b_v[m]  = v_q[m];
            b_ia[m] = ia_q[m];
            b_ib[m] = ib_q[m];
            b_l[m]  = llr_q[m];
         end
      end
      for (int m = 0; m < DEPTH; m++) begin
         le[m] = b_v[m] && (b_l[m] <= ins_llr);
      end
      for (int m = 0; m < DEPTH; m++) begin
         dn = (m > 0) ? m - 1 : 0;
         if (!ins_valid || le[m]) begin
            v_d[m]   = b_v[m];
            ia_d[m]  = b_ia[m];
            ib_d[m]  = b_ib[m];
            llr_d[m] = b_l[m];
         end else if (m == 0 || le[dn]) begin
            v_d[m]   = 1'b1;
            ia_d[m]  = ins_ia;
            ib_d[m]  = ins_ib;
            llr_d[m] = ins_llr;
         end else begin
            v_d[m]   = b_v[dn];
            ia_d[m]  = b_ia[dn];
            ib_d[m]  = b_ib[dn];
            llr_d[m] = b_l[dn];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q   <= '0;
         ia_q  <= '0;
         ib_q  <= '0;
         llr_q <= '0;
      end else if (clear) begin
         v_q   <= '0;
      end else begin
         v_q   <= v_d;
         ia_q  <= ia_d;
         ib_q  <= ib_d;
         llr_q <= llr_d;
      end
   end

   assign head_valid = v_q[0];
   assign head_ia    = ia_q[0];
   assign head_ib    = ib_q[0];
   assign head_llr   = llr_q[0];

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && !pop && !clear) |-> !v_q[DEPTH-1])
      else $error("sorter overflow");

   genvar g;
   for (g = 0; g < DEPTH - 1; g++) begin : g_order
      assert_sorted_R5: assert property (@(posedge clk) disable iff (!rst_n)
         v_q[g+1] |-> (v_q[g] && (llr_q[g] <= llr_q[g+1])))
         else $error("sorter order broken");
   end
endmodule

// File: rtl/ecn_successor.sv
`timescale 1ns/1ps
module ecn_successor #(
   parameter int NM    = 12,
   parameter int DEPTH = 6,
   parameter int IDX_W = 4,
   parameter int PTR_W = 4,
   parameter int LLR_W = 8,
   parameter int SUM_W = 9
) (
   input  logic [IDX_W-1:0]          row,
   input  logic [IDX_W-1:0]          col,
   input  logic [NM-1:0][LLR_W-1:0]  llr_a,
   input  logic [NM-1:0][LLR_W-1:0]  llr_b,
   input  logic [NM-1:0][PTR_W-1:0]  ptr,
   output logic                      nxt_valid,
   output logic [IDX_W-1:0]          nxt_row,
   output logic [IDX_W-1:0]          nxt_col,
   output logic [SUM_W-1:0]          nxt_llr
);
   int               r_i, c_i, o_i;
   logic             own_ok, oth_ok;
   logic [IDX_W-1:0] own_col, oth_row, oth_col;
   logic [SUM_W-1:0] own_sum, oth_sum;

   always_comb begin
      r_i     = int'(row);
      c_i     = int'(col);
      own_ok  = (c_i + 1) < NM;
      own_col = own_ok ? IDX_W'(c_i + 1) : '0;
      own_sum = SUM_W'(llr_a[row]) + SUM_W'(llr_b[own_col]);
      o_i     = ecn_pkg::partner_row(r_i, DEPTH);
      oth_row = (o_i < NM) ? IDX_W'(o_i) : '0;
      oth_ok  = (o_i < NM) && (int'(ptr[oth_row]) < NM);
      oth_col = oth_ok ? IDX_W'(ptr[oth_row]) : '0;
      oth_sum = SUM_W'(llr_a[oth_row]) + SUM_W'(llr_b[oth_col]);
      if (oth_ok && (!own_ok || (oth_sum < own_sum))) begin
         nxt_valid = 1'b1;
         nxt_row   = oth_row;
         nxt_col   = oth_col;
         nxt_llr   = oth_sum;
      end else begin
         nxt_valid = own_ok;
         nxt_row   = row;
         nxt_col   = own_col;
         nxt_llr   = own_sum;
      end
   end
endmodule

// File: rtl/ecn_dedup.sv
`timescale 1ns/1ps
module ecn_dedup #(
   parameter int NM    = 12,
   parameter int SYM_W = 8,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [SYM_W-1:0] probe_sym,
   input  logic             record,
   output logic             hit,
   output logic [CNT_W-1:0] cnt_o
);
   logic [NM-1:0][SYM_W-1:0] list_q;
   logic [CNT_W-1:0]         cnt_q;

   always_comb begin
      hit = 1'b0;
      for (int k = 0; k < NM; k++) begin
         if (k < int'(cnt_q) && list_q[k] == probe_sym) hit = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         list_q <= '0;
         cnt_q  <= '0;
      end else if (clear) begin
         cnt_q  <= '0;
      end else if (record && int'(cnt_q) < NM) begin
         list_q[cnt_q] <= probe_sym;
         cnt_q         <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

   assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) <= NM)
      else $error("emitted list overrun");

   assert_no_full_record_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (record && !clear) |-> (int'(cnt_q) < NM))
      else $error("record after list full");
endmodule

// File: rtl/ecn_pair_merge.sv
`timescale 1ns/1ps
module ecn_pair_merge #(
   parameter int NM    = 12,
   parameter int SYM_W = 8,
   parameter int LLR_W = 8,
   parameter int DEPTH = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [NM*SYM_W-1:0]   a_sym_i,
   input  logic [NM*LLR_W-1:0]   a_llr_i,
   input  logic [NM*SYM_W-1:0]   b_sym_i,
   input  logic [NM*LLR_W-1:0]   b_llr_i,
   output logic                  busy_o,
   output logic                  out_valid_o,
   output logic [SYM_W-1:0]      out_sym_o,
   output logic [LLR_W:0]        out_llr_o,
   output logic                  out_done_o
);
   import ecn_pkg::*;

   localparam int IDX_W = (NM > 1) ? $clog2(NM) : 1;
   localparam int PTR_W = $clog2(NM + 1);
   localparam int SUM_W = LLR_W + 1;

   initial begin
      assert (DEPTH >= 1 && DEPTH <= NM && NM <= 2 * DEPTH)
         else $error("ecn_pair_merge: DEPTH must lie in [NM/2, NM]");
      assert (SYM_W >= 1 && LLR_W >= 1)
         else $error("ecn_pair_merge: bad widths");
   end

   ecn_state_e                state_q;
   logic [IDX_W-1:0]          load_q;
   logic [NM-1:0][SYM_W-1:0]  a_sym_q, b_sym_q;
   logic [NM-1:0][LLR_W-1:0]  a_llr_q, b_llr_q;
   logic [NM-1:0][PTR_W-1:0]  ptr_q;

   logic             accept, in_load, in_run, pop;
   logic             ins_valid;
   logic [IDX_W-1:0] ins_ia, ins_ib;
   logic [SUM_W-1:0] ins_llr;
   logic             head_v;
   logic [IDX_W-1:0] head_ia, head_ib;
   logic [SUM_W-1:0] head_llr;
   logic             nxt_valid;
   logic [IDX_W-1:0] nxt_row, nxt_col;
   logic [SUM_W-1:0] nxt_llr;
   logic [SYM_W-1:0] head_sym;
   logic             hit, record;
   logic [PTR_W-1:0] emitted;

   assign accept  = start_i && (state_q == ST_IDLE);
   assign in_load = (state_q == ST_LOAD);
   assign in_run  = (state_q == ST_RUN);
   assign pop     = in_run && head_v;
   assign record  = pop && !hit;
   assign busy_o  = (state_q != ST_IDLE);

   always_comb begin
      if (in_load) begin
         ins_valid = 1'b1;
         ins_ia    = load_q;
         ins_ib    = '0;
         ins_llr   = SUM_W'(a_llr_q[load_q]) + SUM_W'(b_llr_q[0]);
      end else begin
         ins_valid = pop && nxt_valid;
         ins_ia    = nxt_row;
         ins_ib    = nxt_col;
         ins_llr   = nxt_llr;
      end
   end

   ecn_insert_sorter #(.DEPTH(DEPTH), .IDX_W(IDX_W), .SUM_W(SUM_W)) u_sorter (
      .clk(clk), .rst_n(rst_n), .clear(accept), .pop(pop),
      .ins_valid(ins_valid), .ins_ia(ins_ia), .ins_ib(ins_ib), .ins_llr(ins_llr),
      .head_valid(head_v), .head_ia(head_ia), .head_ib(head_ib), .head_llr(head_llr)
   );

   ecn_successor #(.NM(NM), .DEPTH(DEPTH), .IDX_W(IDX_W), .PTR_W(PTR_W),
                   .LLR_W(LLR_W), .SUM_W(SUM_W)) u_succ (
      .row(head_ia), .col(head_ib), .llr_a(a_llr_q), .llr_b(b_llr_q), .ptr(ptr_q),
      .nxt_valid(nxt_valid), .nxt_row(nxt_row), .nxt_col(nxt_col), .nxt_llr(nxt_llr)
   );

   assign head_sym = a_sym_q[head_ia] ^ b_sym_q[head_ib];

   ecn_dedup #(.NM(NM), .SYM_W(SYM_W), .CNT_W(PTR_W)) u_dedup (
      .clk(clk), .rst_n(rst_n), .clear(accept), .probe_sym(head_sym),
      .record(record), .hit(hit), .cnt_o(emitted)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         load_q      <= '0;
         a_sym_q     <= '0;
         b_sym_q     <= '0;
         a_llr_q     <= '0;
         b_llr_q     <= '0;
         ptr_q       <= '0;
         out_valid_o <= 1'b0;
         out_sym_o   <= '0;
         out_llr_o   <= '0;
         out_done_o  <= 1'b0;
      end else begin
         out_valid_o <= 1'b0;
         out_done_o  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  a_sym_q <= a_sym_i;
                  b_sym_q <= b_sym_i;
                  a_llr_q <= a_llr_i;
                  b_llr_q <= b_llr_i;
                  ptr_q   <= '0;
                  load_q  <= '0;
                  state_q <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               if (load_q == IDX_W'(DEPTH - 1)) state_q <= ST_RUN;
               else                              load_q  <= load_q + 1'b1;
            end
            ST_RUN: begin
               if (!head_v) begin
                  out_done_o <= 1'b1;
                  state_q    <= ST_IDLE;
               end else begin
                  ptr_q[head_ia] <= PTR_W'(int'(head_ib) + 1);
                  if (!hit) begin
                     out_valid_o <= 1'b1;
                     out_sym_o   <= head_sym;
                     out_llr_o   <= head_llr;
                     if (emitted == PTR_W'(NM - 1)) begin
                        out_done_o <= 1'b1;
                        state_q    <= ST_IDLE;
                     end
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // ordering history for the output checks below
   logic [SUM_W-1:0] prev_llr_q;
   logic             have_prev_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_llr_q  <= '0;
         have_prev_q <= 1'b0;
      end else if (accept) begin
         have_prev_q <= 1'b0;
      end else if (out_valid_o) begin
         prev_llr_q  <= out_llr_o;
         have_prev_q <= 1'b1;
      end
   end

   assert_out_nondecr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && have_prev_q) |-> (out_llr_o >= prev_llr_q))
      else $error("output cost decreased");

   assert_first_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !have_prev_q) |->
         (out_llr_o == SUM_W'(a_llr_q[0]) + SUM_W'(b_llr_q[0]) &&
          out_sym_o == (a_sym_q[0] ^ b_sym_q[0])))
      else $error("first output is not the head pair");

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_done_o |-> !busy_o)
      else $error("done while busy");

   assert_ignore_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> ($stable(a_llr_q) && $stable(b_sym_q)))
      else $error("capture changed during a run");
endmodule

// File: tb/tb_ecn_pair_merge.sv
`timescale 1ns/1ps
module tb_ecn_pair_merge;
   localparam int NM    = 12;
   localparam int SYM_W = 8;
   localparam int LLR_W = 8;
   localparam int DEPTH = 6;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start_i = 1'b0;
   logic [NM*SYM_W-1:0] a_sym_i = '0, b_sym_i = '0;
   logic [NM*LLR_W-1:0] a_llr_i = '0, b_llr_i = '0;
   logic                busy_o, out_valid_o, out_done_o;
   logic [SYM_W-1:0]    out_sym_o;
   logic [LLR_W:0]      out_llr_o;

   ecn_pair_merge #(.NM(NM), .SYM_W(SYM_W), .LLR_W(LLR_W), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .a_sym_i(a_sym_i), .a_llr_i(a_llr_i), .b_sym_i(b_sym_i), .b_llr_i(b_llr_i),
      .busy_o(busy_o), .out_valid_o(out_valid_o), .out_sym_o(out_sym_o),
      .out_llr_o(out_llr_o), .out_done_o(out_done_o)
   );

   always #5 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   int va_sym[NM], vb_sym[NM], va_llr[NM], vb_llr[NM];
   int best[256];
   int ref_llr[NM];
   int got_sym[NM], got_llr[NM];
   logic [15:0] lfsr = 16'hACE1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int rnd();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return int'(lfsr);
   endfunction

   task automatic drive_buses();
      for (int k = 0; k < NM; k++) begin
         a_sym_i[k*SYM_W +: SYM_W] = SYM_W'(va_sym[k]);
         b_sym_i[k*SYM_W +: SYM_W] = SYM_W'(vb_sym[k]);
         a_llr_i[k*LLR_W +: LLR_W] = LLR_W'(va_llr[k]);
         b_llr_i[k*LLR_W +: LLR_W] = LLR_W'(vb_llr[k]);
      end
   endtask

   task automatic build_reference();
      bit used[256];
      for (int s = 0; s < 256; s++) begin best[s] = 1 << 20; used[s] = 1'b0; end
      for (int i = 0; i < NM; i++)
         for (int j = 0; j < NM; j++) begin
            int s = (va_sym[i] ^ vb_sym[j]) & 255;
            if (va_llr[i] + vb_llr[j] < best[s]) best[s] = va_llr[i] + vb_llr[j];
         end
      for (int k = 0; k < NM; k++) begin
         int bs = -1;
         for (int s = 0; s < 256; s++)
            if (!used[s] && best[s] < (1 << 20) && (bs < 0 || best[s] < best[bs])) bs = s;
         used[bs] = 1'b1;
         ref_llr[k] = best[bs];
      end
   endtask

   // gap_mode: 1 = outputs must be back to back, 2 = at least one gap, 0 = either
   task automatic run_case(input string name, input int gap_mode, input bit poke);
      int n_got = 0, first_c = -1, last_c = -1;
      bit done_seen = 1'b0, done_busy = 1'b0, done_valid = 1'b0;
      build_reference();
      @(negedge clk);
      drive_buses();
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int c = 1; c < 400; c++) begin
         @(negedge clk);
         if (out_valid_o) begin
            if (n_got < NM) begin
               got_sym[n_got] = int'(out_sym_o);
               got_llr[n_got] = int'(out_llr_o);
            end
            n_got++;
            if (first_c < 0) first_c = c;
            last_c = c;
         end
         if (poke && c == 3) begin
            a_sym_i = ~a_sym_i;
            a_llr_i = '0;
            start_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
         if (out_done_o) begin
            done_seen = 1'b1; done_busy = busy_o; done_valid = out_valid_o;
            break;
         end
      end
      $display("case %s: %0d outputs", name, n_got);
      check(done_seen, "R8", {name, " done pulse"}, int'(done_seen), 1);
      check(!done_busy && done_valid, "R8", {name, " done with last output, idle"},
            int'(done_busy), 0);
      check(n_got == NM, "R3", {name, " output count"}, n_got, NM);
      check(first_c == DEPTH + 1, "R6", {name, " first output latency"}, first_c, DEPTH + 1);
      if (n_got >= 1) begin
         check(got_llr[0] == 0, "R5", {name, " first cost"}, got_llr[0], 0);
         check(got_sym[0] == ((va_sym[0] ^ vb_sym[0]) & 255), "R5", {name, " first symbol"},
               got_sym[0], (va_sym[0] ^ vb_sym[0]) & 255);
      end
      for (int k = 0; k < NM && k < n_got; k++) begin
         bit pair_ok = 1'b0;
         bit dup = 1'b0;
         for (int i = 0; i < NM; i++)
            for (int j = 0; j < NM; j++)
               if (((va_sym[i] ^ vb_sym[j]) & 255) == got_sym[k] &&
                   va_llr[i] + vb_llr[j] == got_llr[k]) pair_ok = 1'b1;
         for (int p = 0; p < k; p++) if (got_sym[p] == got_sym[k]) dup = 1'b1;
         check(pair_ok, "R2", {name, " symbol/cost from a pair"}, got_sym[k], got_llr[k]);
         check(got_llr[k] == ref_llr[k], "R3", {name, " rank cost"}, got_llr[k], ref_llr[k]);
         check(best[got_sym[k]] == got_llr[k], "R3", {name, " best cost of symbol"},
               got_llr[k], best[got_sym[k]]);
         check(!dup, "R4", {name, " distinct symbol"}, got_sym[k], -1);
         if (k > 0)
            check(got_llr[k] >= got_llr[k-1], "R5", {name, " nondecreasing"},
                  got_llr[k], got_llr[k-1]);
      end
      if (gap_mode == 1)
         check(last_c - first_c == NM - 1, "R6", {name, " back-to-back span"},
               last_c - first_c, NM - 1);
      if (gap_mode == 2)
         check(last_c - first_c > NM - 1, "R7", {name, " duplicate gap span"},
               last_c - first_c, NM);
      if (poke) begin
         bit extra = 1'b0;
         for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (out_valid_o || busy_o) extra = 1'b1;
         end
         check(!extra, "R1", {name, " start during run ignored"}, int'(extra), 0);
      end
   endtask

   task automatic test_reset();
      check(!busy_o, "R10", "reset busy", int'(busy_o), 0);
      check(!out_valid_o, "R10", "reset valid", int'(out_valid_o), 0);
      check(!out_done_o, "R10", "reset done", int'(out_done_o), 0);
   endtask

   task automatic test_column_deep();   // R9: rows beyond the preload
      for (int k = 0; k < NM; k++) begin
         va_sym[k] = (k * 37 + 5) & 255;  va_llr[k] = k;
         vb_sym[k] = (k * 11 + 200) & 255; vb_llr[k] = (k == 0) ? 0 : 100 + k;
      end
      run_case("column_deep_R9", 1, 1'b0);
      for (int k = 0; k < NM; k++)
         check(got_sym[k] == ((va_sym[k] ^ vb_sym[0]) & 255), "R9", "column-0 row order",
               got_sym[k], (va_sym[k] ^ vb_sym[0]) & 255);
   endtask

   task automatic test_row_deep();
      for (int k = 0; k < NM; k++) begin
         va_sym[k] = (k * 53 + 9) & 255;  va_llr[k] = (k == 0) ? 0 : 120 + k;
         vb_sym[k] = (k * 7 + 1) & 255;   vb_llr[k] = 2 * k;
      end
      run_case("row_deep_R6", 1, 1'b0);
   endtask

   task automatic test_duplicates();    // R7
      for (int k = 0; k < NM; k++) begin
         va_sym[k] = k; vb_sym[k] = k; va_llr[k] = 2 * k; vb_llr[k] = 2 * k;
      end
      run_case("duplicates_R7", 2, 1'b0);
   endtask

   task automatic load_random();
      int mula = rnd() | 1, mulb = rnd() | 1, offa = rnd(), offb = rnd();
      va_llr[0] = 0; vb_llr[0] = 0;
      for (int k = 0; k < NM; k++) begin
         va_sym[k] = (k * mula + offa) & 255;
         vb_sym[k] = (k * mulb + offb) & 255;
         if (k > 0) begin
            va_llr[k] = va_llr[k-1] + (rnd() & 15);
            vb_llr[k] = vb_llr[k-1] + (rnd() & 15);
         end
      end
   endtask

   task automatic test_random();
      for (int t = 0; t < 6; t++) begin
         load_random();
         run_case($sformatf("random%0d_R3", t), 0, 1'b0);
      end
   endtask

   task automatic test_busy_start();    // R1
      load_random();
      run_case("busy_start_R1", 0, 1'b1);
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_column_deep();
      test_row_deep();
      test_duplicates();
      test_random();
      test_busy_start();
      repeat (3) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule